// File: doc/BRIEF.md
# Q3.12 Fixed-Point Add/Multiply Unit

This block performs one signed fixed-point operation on 16-bit words made of a sign bit, three integer bits and twelve fraction bits. The two operands arrive on separate valid/ready channels and wait in their own small queues. Results wait in an output queue until the consumer takes them. A build-time parameter chooses addition or multiplication. The block contains no other arithmetic.

A compute step takes the head of each operand queue and writes one result into the output queue. It does so only when both operand queues hold data and the output queue can accept a word. All three queues behave as pipeline queues. A slot freed by a pop in a cycle can be refilled by a push in the same cycle. Newly pushed data cannot be consumed until the next cycle. The producers and the consumer can therefore stall at any time without losing or reordering data.

Top module: `fxp_arith_unit`

## Requirements
- R1: With MULT=0, each result equals the sum of the paired operand words taken modulo 2^16, so 0x7000 + 0x1000 gives 0x8000.
- R2: With MULT=1, each result is bits [27:12] of the 32-bit two's-complement product of the two sign-extended operands. Fraction bits below weight 2^-12 are dropped, which rounds toward minus infinity, and overflow wraps. For example, 0xF800 × 0x1800 (−0.5 × 1.5) gives 0xF400 (−0.75), 0x4000 × 0x4000 gives 0x0000, and 0xFFFF × 0x0800 gives 0xFFFF.
- R3: A compute step fires only when both operand queues are non-empty and the output queue is not full or is being popped in the same cycle. When these conditions hold, the step fires.
- R4: If an operand pair is accepted at clock edge k and all queues were empty, res_valid rises after edge k+1.
- R5: Operands are paired strictly in arrival order on each channel, and results leave in the order their pairs were formed.
- R6: a_ready is high when the A queue holds fewer than DEPTH words or a compute step fires in that cycle. b_ready follows the same rule for the B queue.
- R7: res_valid is high exactly when the output queue is non-empty. While res_valid is high and res_ready is low, res_valid and res_data hold their values.
- R8: After reset, all queues are empty, res_valid is low, and a_ready and b_ready are high.
- R9: A push with valid high while the matching ready is low is ignored, and it never appears in a later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Operand A offered |
| a_data | input | 16 | Operand A, Q3.12 two's complement |
| a_ready | output | 1 | Operand A queue can accept |
| b_valid | input | 1 | Operand B offered |
| b_data | input | 16 | Operand B, Q3.12 two's complement |
| b_ready | output | 1 | Operand B queue can accept |
| res_valid | output | 1 | Result queue has a word at its head |
| res_data | output | 16 | Head result word |
| res_ready | input | 1 | Consumer takes the head result |

## Verification
The hardest case to reach is a cycle in which every queue is full, the consumer pops a result, a compute step fires into the slot just freed, and both producers push into the operand slots the step has freed. In that cycle ready depends on same-cycle activity further down the block. To reach it, the stimulus first holds res_ready low while both producers keep pushing until all queues fill. It then runs thousands of cycles with independent random valid and ready levels, and these often pass through the full state. Directed pairs cover the worked multiplication example, wrap in both modes and truncation of a negative product.

// File: rtl/fxp_arith_unit.sv
module fxp_arith_unit #(
  parameter int DEPTH     = 2,
  parameter bit MULT      = 1'b1,
  parameter int INT_BITS  = 3,
  parameter int FRAC_BITS = 12,
  localparam int W   = 1 + INT_BITS + FRAC_BITS,
  localparam int PW  = 2 * W,
  localparam int PTR = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_valid,
  input  logic [W-1:0] a_data,
  output logic         a_ready,
  input  logic         b_valid,
  input  logic [W-1:0] b_data,
  output logic         b_ready,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  input  logic         res_ready
);

  function automatic logic [PTR-1:0] step_ptr(input logic [PTR-1:0] p);
    return (p == PTR'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]   a_mem [DEPTH];
  logic [W-1:0]   b_mem [DEPTH];
  logic [W-1:0]   r_mem [DEPTH];
  logic [PTR-1:0] a_wp, a_rp, b_wp, b_rp, r_wp, r_rp;
  logic [CW-1:0]  a_cnt, b_cnt, r_cnt;
  logic [W-1:0]   alu;
  logic           a_push, b_push, r_pop, fire;

  assign r_pop     = res_valid && res_ready;
  assign fire      = (a_cnt != '0) && (b_cnt != '0) && ((r_cnt != CW'(DEPTH)) || r_pop);
  assign a_ready   = (a_cnt != CW'(DEPTH)) || fire;
  assign b_ready   = (b_cnt != CW'(DEPTH)) || fire;
  assign a_push    = a_valid && a_ready;
  assign b_push    = b_valid && b_ready;
  assign res_valid = (r_cnt != '0);
  assign res_data  = r_mem[r_rp];

  generate
    if (MULT) begin : g_mul
      logic [PW-1:0] ext_a, ext_b, prod;
      assign ext_a = {{W{a_mem[a_rp][W-1]}}, a_mem[a_rp]};
      assign ext_b = {{W{b_mem[b_rp][W-1]}}, b_mem[b_rp]};
      assign prod  = ext_a * ext_b;
      assign alu   = W'(prod >> FRAC_BITS);
    end else begin : g_add
      assign alu = a_mem[a_rp] + b_mem[b_rp];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_wp <= '0; a_rp <= '0; a_cnt <= '0;
      b_wp <= '0; b_rp <= '0; b_cnt <= '0;
      r_wp <= '0; r_rp <= '0; r_cnt <= '0;
    end else begin
      if (a_push) begin
        a_mem[a_wp] <= a_data;
        a_wp <= step_ptr(a_wp);
      end
      if (b_push) begin
        b_mem[b_wp] <= b_data;
        b_wp <= step_ptr(b_wp);
      end
      if (fire) begin
        r_mem[r_wp] <= alu;
        r_wp <= step_ptr(r_wp);
        a_rp <= step_ptr(a_rp);
        b_rp <= step_ptr(b_rp);
      end
      if (r_pop) r_rp <= step_ptr(r_rp);
      a_cnt <= a_cnt + CW'(a_push) - CW'(fire);
      b_cnt <= b_cnt + CW'(b_push) - CW'(fire);
      r_cnt <= r_cnt + CW'(fire) - CW'(r_pop);
    end
  end

endmodule

// File: rtl/fxp_arith_unit_chk.sv
module fxp_arith_unit_chk #(
  parameter int DEPTH = 2,
  parameter int W     = 16,
  parameter int CW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_ready,
  input logic          b_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  res_data,
  input logic          fire,
  input logic [CW-1:0] a_cnt,
  input logic [CW-1:0] b_cnt,
  input logic [CW-1:0] r_cnt
);

  // R3
  fire_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (a_cnt != '0) && (b_cnt != '0) && ((r_cnt != CW'(DEPTH)) || (res_valid && res_ready)));

  // R4
  fire_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);

  // R6
  a_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cnt < CW'(DEPTH)) |-> a_ready);

  // R6
  b_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_cnt < CW'(DEPTH)) |-> b_ready);

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R8
  reset_empty_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!res_valid && a_ready && b_ready));

endmodule

bind fxp_arith_unit fxp_arith_unit_chk #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_ready(a_ready), .b_ready(b_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .fire(fire), .a_cnt(a_cnt), .b_cnt(b_cnt), .r_cnt(r_cnt)
);

// File: tb/tb_fxp_arith_unit.sv
module tb_fxp_arith_unit;
  localparam int CLK_PERIOD = 10;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0, res_ready = 1'b0;
  logic [15:0] a_data = '0, b_data = '0;
  logic a_ready, b_ready, res_valid, aa_ready, ab_ready, ares_valid;
  logic [15:0] res_data, ares_data;

  int total = 0;
  int bad = 0;
  logic [15:0] aq[$], bq[$], rqa[$], rqm[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fxp_arith_unit #(.DEPTH(D), .MULT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready));

  fxp_arith_unit #(.DEPTH(D), .MULT(1'b0)) dut_add (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_data(a_data), .a_ready(aa_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(ab_ready),
    .res_valid(ares_valid), .res_data(ares_data), .res_ready(res_ready));

  function automatic logic [15:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
    int px, py, p;
    px = $signed(x);
    py = $signed(y);
    p = px * py;
    return 16'(p >>> 12);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic av, input logic [15:0] ad, input logic bv,
                     input logic [15:0] bd, input logic rr);
    logic fire_e, ar_e, br_e;
    @(negedge clk);
    a_valid = av; a_data = ad; b_valid = bv; b_data = bd; res_ready = rr;
    #1;
    // R3 / R6 / R9: expected readies from model occupancy
    fire_e = (aq.size() > 0) && (bq.size() > 0) &&
             ((rqm.size() < D) || ((rqm.size() > 0) && rr));
    ar_e = (aq.size() < D) || fire_e;
    br_e = (bq.size() < D) || fire_e;
    check("R6 a_ready", 16'(a_ready), 16'(ar_e));
    check("R6 b_ready", 16'(b_ready), 16'(br_e));
    check("R6 add a_ready", 16'(aa_ready), 16'(ar_e));
    check("R6 add b_ready", 16'(ab_ready), 16'(br_e));
    // R4 / R7: valid tracks output queue occupancy
    check("R7 res_valid", 16'(res_valid), 16'(rqm.size() > 0));
    check("R7 add res_valid", 16'(ares_valid), 16'(rqa.size() > 0));
    // R2 / R5: multiply results in pair order
    if (rqm.size() > 0) check("R2 R5 mul data", res_data, rqm[0]);
    // R1 / R5: add results in pair order
    if (rqa.size() > 0) check("R1 R5 add data", ares_data, rqa[0]);
    @(posedge clk);
    if (rqm.size() > 0 && rr) begin
      void'(rqm.pop_front());
      void'(rqa.pop_front());
    end
    if (fire_e) begin
      logic [15:0] x, y;
      x = aq.pop_front();
      y = bq.pop_front();
      rqa.push_back(x + y);
      rqm.push_back(ref_mul(x, y));
    end
    if (av && ar_e) aq.push_back(ad);
    if (bv && br_e) bq.push_back(bd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8
    check("R8 res_valid", 16'(res_valid), 16'h0);
    check("R8 a_ready", 16'(a_ready), 16'h1);
    check("R8 b_ready", 16'(b_ready), 16'h1);
    check("R8 add res_valid", 16'(ares_valid), 16'h0);

    // R2 worked example and R4 latency: push at edge k, result visible after k+1
    cyc(1, 16'hF800, 1, 16'h1800, 0);
    #2;
    check("R4 not yet valid", 16'(res_valid), 16'h0);
    cyc(0, 16'h0, 0, 16'h0, 0);
    #2;
    check("R4 valid after k+1", 16'(res_valid), 16'h1);
    check("R2 -0.5*1.5", res_data, 16'hF400);
    check("R1 -0.5+1.5", ares_data, 16'h1000);
    cyc(0, 16'h0, 0, 16'h0, 1);

    // R1 add wrap and R2 mul wrap and truncation
    cyc(1, 16'h7000, 1, 16'h1000, 1);
    cyc(1, 16'h4000, 1, 16'h4000, 1);
    cyc(1, 16'hFFFF, 1, 16'h0800, 1);
    repeat (4) cyc(0, 16'h0, 0, 16'h0, 1);

    // R5 unequal arrival: A runs ahead of B
    cyc(1, 16'h1000, 0, 16'h0, 1);
    cyc(1, 16'h2000, 0, 16'h0, 1);
    cyc(0, 16'h0, 1, 16'h3000, 1);
    cyc(0, 16'h0, 1, 16'hE000, 1);
    repeat (4) cyc(0, 16'h0, 0, 16'h0, 1);

    // R3 R9 back-pressure: fill every queue, offers beyond capacity are ignored
    for (int i = 0; i < 10; i++) cyc(1, 16'($urandom), 1, 16'($urandom), 0);
    // R3 full queues with simultaneous pop, fire and push
    for (int i = 0; i < 10; i++) cyc(1, 16'($urandom), 1, 16'($urandom), 1);

    // random traffic
    for (int i = 0; i < 4000; i++)
      cyc(1'($urandom % 4 != 0), 16'($urandom), 1'($urandom % 3 != 0),
          16'($urandom), 1'($urandom % 2));
    repeat (10) cyc(0, 16'h0, 0, 16'h0, 1);
    check("R5 drained", 16'(res_valid), 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule